// File: doc/BRIEF.md
# Up/Down Pulse-Count Decimation Filter

This block is the digital back end of a counting oversampled converter. Each clock cycle a comparator may raise an "up" strobe, a "down" strobe, both or neither. The block turns these strobes into a signed step of +1, -1 or 0; a cycle with both strobes gives 0. The step stream then passes through a cascade of reversible counters that each get wider. Every stage first smooths its input by adding each sample to the one before it. It then accumulates the smoothed samples, and at regular intervals empties its whole content into the next stage.

Stage k is 4 + 2k bits wide (with the default parameters). It dumps once every 2^(k+1) cycles, so each stage runs at half the rate of the stage before it. The dump ticks come from a chain of divide-by-two toggle flops. Odd-numbered stages keep their count in one's-complement (inverted) code, and even-numbered stages keep it in plain two's complement. Every readout and the final result are converted back to true two's complement.

The last stage's dump value is registered and presented with a one-cycle valid strobe. A truncated copy of the same value drops the lowest quarter of its bits, which carry only quantization noise. The number of stages is a parameter. It is chosen so that the final dump rate equals the target output (Nyquist) rate.

Top module: `qdf_decimator`

## Requirements
- R1: An up strobe alone is a step of +1 and a down strobe alone is a step of -1. A cycle with both strobes, or with neither, is a step of 0, so a run of coincident strobes leaves the final result at 0.
- R2: Each stage's increment equals its present input sample plus the sample it took at its previous input event. Before the first input event that previous sample is 0. Stage 0 takes the step every cycle. Stage k>0 takes the readout of stage k-1 whenever stage k-1 dumps.
- R3: Stage k is W0 + WSTEP*k bits wide (4, 6, 8, 10 by default) and never overflows for any strobe pattern. The final result is WF = W0 + WSTEP*(STAGES-1) bits wide.
- R4: Counting cycles from t=0 at the first rising edge after reset is released, stage k dumps in every cycle where t mod 2^(k+1) equals 2^(k+1)-1. A stage dumps only in a cycle in which it also takes an input.
- R5: A dump is destructive. The dumped value is the stage content from before that edge, and after the edge the stage holds only the increment of that same cycle.
- R6: Odd stages hold their count in inverted code internally. Every stage readout and res_o are true two's-complement values.
- R7: res_vld_o is high for exactly one cycle, one cycle after each dump of the last stage, and so once every 2^STAGES cycles. res_o takes the new value in that cycle and holds it until the next strobe.
- R8: trunc_o equals res_o shifted right arithmetically by WF/4 bits (its top WF - WF/4 bits), which is floor(res_o / 2^(WF/4)).
- R9: During reset res_o is 0, trunc_o is 0 and res_vld_o is 0.
- R10: A constant up strobe settles res_o at +2^(2*STAGES) (256 by default), and a constant down strobe settles it at -256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Up event strobe for this cycle |
| dn_i | input | 1 | Down event strobe for this cycle |
| res_o | output | WF (10) | Final-stage dump value, signed two's complement |
| res_vld_o | output | 1 | One-cycle strobe marking a new res_o |
| trunc_o | output | WF - WF/4 (8) | res_o with the noise LSBs removed |

## Verification
The in-design assertions assume that the strobes are ordinary synchronous levels, sampled once per cycle, and that any combination of the two is legal, including both together. The no-overflow property holds only because a stage's input magnitude is bounded by the width of the stage before it. It therefore relies on the stimulus being the only source of steps, with no value injected between stages. The bench drives the strobes only at falling edges. It mixes long constant runs (all up, all down, all coincident) with random patterns that include coincident cycles. This drives every stage to both full-scale extremes and through the cancellation path, while the strobes always stay inside the legal per-cycle encoding.

// File: rtl/qdf_pkg.sv
package qdf_pkg;

  // Width of cascade stage k: grows by a fixed step per stage.
  function automatic int stage_w(input int w0, input int wstep, input int k);
    return w0 + wstep * k;
  endfunction

  // Net signed step for one cycle; coincident strobes cancel.
  function automatic logic signed [1:0] net_step(input logic up, input logic dn);
    if (up && !dn) return 2'sb01;
    if (dn && !up) return 2'sb11;
    return 2'sb00;
  endfunction

endpackage

// File: rtl/qdf_cancel.sv
module qdf_cancel (
  input  logic              up_i,
  input  logic              dn_i,
  output logic signed [1:0] step_o
);
  import qdf_pkg::*;

  always_comb step_o = net_step(up_i, dn_i);

endmodule

// File: rtl/qdf_ticks.sv
module qdf_ticks #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] dump_o
);
  logic [N-1:0] tog;
  logic [N:0]   en;

  assign en[0] = 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_tog
    assign en[k+1] = en[k] & tog[k];

    always_ff @(posedge clk) begin
      if (!rst_n)     tog[k] <= 1'b0;
      else if (en[k]) tog[k] <= ~tog[k];
    end

    if (k > 0) begin : g_chk
      // R4: a slower stage only dumps together with every faster one
      p_nested_dump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dump_o[k] |-> dump_o[k-1]);
    end
  end

  assign dump_o = en[N:1];

endmodule

// File: rtl/qdf_stage.sv
module qdf_stage #(
  parameter int W   = 4,
  parameter int IW  = 2,
  parameter bit ODD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic                 dump_en,
  input  logic signed [IW-1:0] in_v,
  output logic signed [W-1:0]  rd_o
);
  localparam logic [W-1:0] CLR = ODD ? {W{1'b1}} : {W{1'b0}};

  logic signed [W-1:0] ext, prev, inc, st, tv, nxt_add, nxt_clr;

  // delay-and-add averager on the stage input
  assign ext = W'(in_v);
  assign inc = ext + prev;

  always_ff @(posedge clk) begin
    if (!rst_n)     prev <= '0;
    else if (in_en) prev <= ext;
  end

  // storage coding picked by stage parity
  if (ODD) begin : g_inv
    assign tv      = ~st;
    assign nxt_add = st - inc;
    assign nxt_clr = ~inc;
  end else begin : g_true
    assign tv      = st;
    assign nxt_add = st + inc;
    assign nxt_clr = inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       st <= CLR;
    else if (dump_en) st <= nxt_clr;
    else if (in_en)   st <= nxt_add;
  end

  assign rd_o = tv;

  // named internal event for the overflow check
  logic signed [W:0] wide_sum;
  assign wide_sum = (W+1)'(tv) + (W+1)'(inc);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && !dump_en) |-> (wide_sum[W] == wide_sum[W-1]));

  p_clear_on_dump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dump_en |=> (rd_o == $past(inc)));

  p_dump_needs_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dump_en |-> in_en);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> $stable(rd_o));

endmodule

// File: rtl/qdf_decimator.sv
module qdf_decimator
  import qdf_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int W0     = 4,
  parameter int WSTEP  = 2,
  localparam int WF    = W0 + WSTEP * (STAGES - 1),
  localparam int TQ    = WF / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_i,
  input  logic               dn_i,
  output logic [WF-1:0]      res_o,
  output logic               res_vld_o,
  output logic [WF-TQ-1:0]   trunc_o
);
  logic signed [1:0]   step;
  logic [STAGES-1:0]   dump;
  logic signed [WF-1:0] res_q;
  logic                vld_q;

  qdf_cancel u_cancel (.up_i(up_i), .dn_i(dn_i), .step_o(step));

  qdf_ticks #(.N(STAGES)) u_ticks (.clk(clk), .rst_n(rst_n), .dump_o(dump));

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    localparam int WK  = stage_w(W0, WSTEP, k);
    localparam int IWK = (k == 0) ? 2 : stage_w(W0, WSTEP, k - 1);
    logic signed [WK-1:0]  rd;
    logic signed [IWK-1:0] src;
    logic                  en;

    if (k == 0) begin : g_first
      assign src = step;
      assign en  = 1'b1;
    end else begin : g_next
      assign src = g_st[k-1].rd;
      assign en  = dump[k-1];
    end

    qdf_stage #(.W(WK), .IW(IWK), .ODD(k % 2 == 1)) u_stage (
      .clk(clk), .rst_n(rst_n), .in_en(en), .dump_en(dump[k]),
      .in_v(src), .rd_o(rd)
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= dump[STAGES-1];
      if (dump[STAGES-1]) res_q <= g_st[STAGES-1].rd;
    end
  end

  assign res_o     = res_q;
  assign res_vld_o = vld_q;
  assign trunc_o   = res_q[WF-1:TQ];

  p_cancel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && dn_i) |-> (step == 2'sb00));

  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> $stable(res_o));

endmodule

// File: tb/qdf_decimator_test.sv
module qdf_decimator_test;
  localparam int N  = 4;
  localparam int WF = 4 + 2 * (N - 1);
  localparam int TQ = WF / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0;
  logic [WF-1:0]    res;
  logic             vld;
  logic [WF-TQ-1:0] tr;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int mv[N], mp[N];
  int mt = 0;
  int exp_res = 0;
  bit exp_vld = 0;

  always #2 clk = ~clk;

  qdf_decimator #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn),
    .res_o(res), .res_vld_o(vld), .trunc_o(tr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural model of one rising edge
  task automatic model_edge(input bit u, input bit d);
    int x, val, rd, period;
    bit en, dmp;
    x = (u == d) ? 0 : (u ? 1 : -1);   // R1
    val = x;
    en = 1;
    exp_vld = 0;
    for (int k = 0; k < N; k++) begin
      if (!en) break;
      period = 1 << (k + 1);
      dmp = ((mt % period) == period - 1);   // R4
      rd = mv[k];
      mv[k] = dmp ? (val + mp[k]) : (mv[k] + val + mp[k]);  // R2, R5
      mp[k] = val;
      if (k == N - 1 && dmp) begin
        exp_vld = 1;
        exp_res = rd;
      end
      val = rd;
      en = dmp;
    end
    mt++;
  endtask

  task automatic cycle_step(input bit u, input bit d);
    up = u;
    dn = d;
    model_edge(u, d);
    @(negedge clk);
    cyc++;
    check(vld == exp_vld, "R7 valid", int'(vld), int'(exp_vld));
    check($signed(res) == exp_res, "R6 result", $signed(res), exp_res);
    check($signed(tr) == (exp_res >>> TQ), "R8 truncated", $signed(tr), exp_res >>> TQ);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin mv[k] = 0; mp[k] = 0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(res == '0, "R9 reset res", int'(res), 0);
    check(tr == '0, "R9 reset trunc", int'(tr), 0);
    check(vld == 1'b0, "R9 reset valid", int'(vld), 0);
    rst_n = 1'b1;

    // R10: full-scale up
    for (int i = 0; i < 200; i++) cycle_step(1, 0);
    check($signed(res) == 256, "R10 full up", $signed(res), 256);
    // R10: full-scale down
    for (int i = 0; i < 200; i++) cycle_step(0, 1);
    check($signed(res) == -256, "R10 full down", $signed(res), -256);
    // R1: coincident strobes cancel
    for (int i = 0; i < 200; i++) cycle_step(1, 1);
    check($signed(res) == 0, "R1 coincident", $signed(res), 0);
    // R2 R3 R4 R5: random mixes, including coincident cycles
    for (int i = 0; i < 800; i++) cycle_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    // biased toward up to stress R3 near full scale
    for (int i = 0; i < 400; i++) cycle_step($urandom_range(0, 9) != 0, $urandom_range(0, 9) == 0);
    // alternating pattern, low-frequency
    for (int i = 0; i < 400; i++) cycle_step(((i / 7) % 2) == 0, ((i / 7) % 2) == 1);
    // idle
    for (int i = 0; i < 100; i++) cycle_step(0, 0);
    check($signed(res) == 0, "R2 idle settles", $signed(res), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule